// File: doc/BRIEF.md
# Exact-LRU Set-Associative Tag Directory

This block keeps the tag directory of a set-associative cache and answers, for one lookup at a time, whether the requested memory block is present. The caller presents a block number (a byte address already shifted right by log2 of the line size). The low bits of the block number, masked with the set count minus one, select the set. The whole block number is stored and compared as the tag. Each set is a list of tags kept in physical recency order. The most recently used tag sits in slot 0 and the least recently used tag sits in the last slot.

Every lookup updates the order, and a read or a write allocates in the same way. On a hit, the matching tag moves to slot 0 and the entries that were ahead of it move down one place. On a miss, the new tag enters slot 0, everything else moves down, and the last slot's tag is lost. Reset clears every entry to zero and there is no valid bit. Block number 0 therefore hits in set 0 straight after reset.

A lookup takes two cycles: one to compare all ways in parallel, and one in which the reordered set has been written back and the result is shown. The set count is a power of two. The associativity may be 1, which gives a direct-mapped directory.

Top module: `lru_tag_dir`

## Requirements
- R1: While reset is asserted and on release, every tag entry is zero, `done_o` is 0, `hit_o` is 0 and `ready_o` is 1 once the internal reset has been released.
- R2: A request is accepted on a rising edge where `req_i` and `ready_o` are both 1. In the next cycle `done_o` is 0 and `ready_o` is 0. In the cycle after that `done_o` is 1 for exactly one cycle, and `hit_o` holds the result.
- R3: A request raised while `ready_o` is 0 is ignored: it produces no `done_o` pulse and leaves the directory contents unchanged.
- R4: The set index is the block number ANDed with (SETS-1). The stored tag is the full block number, so two blocks that share the low bits but differ in the upper bits never alias.
- R5: A lookup whose tag is in slot 0 reports a hit and leaves the order of that set unchanged.
- R6: A lookup whose tag is in slot i > 0 reports a hit. The tag moves to slot 0 and slots 0..i-1 each move down one place.
- R7: A miss writes the tag into slot 0, shifts every entry down one place and discards the last slot. After WAYS other blocks have missed in the same set, the oldest block misses again.
- R8: Since entries reset to zero with no valid bit, block number 0 reports a hit on its first lookup after reset.
- R9: `ready_o` is 1 in the cycle where `done_o` is 1. A request accepted there is checked against the already updated order of its set.
- R10: With WAYS = 1 the directory is direct-mapped: a lookup hits only if its block is the last one looked up in that set.
- R11: A lookup changes only the set it indexes. The order of every other set is preserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_i | input | 1 | Lookup request strobe |
| blk_i | input | BLK_W | Block number to look up |
| ready_o | output | 1 | The block can accept a request this cycle |
| done_o | output | 1 | One-cycle pulse marking a completed lookup |
| hit_o | output | 1 | Result of the last completed lookup: 1 hit, 0 miss |

## Verification
A wrong recency order does not show at once. It shows as an unexpected hit or miss only when a later lookup reaches the slot that was misplaced. The bench therefore follows each reordering with lookups chosen so that the next eviction, or the absence of one, reveals the exact order, often several lookups later. Corruption of a neighbouring set, or a request taken while busy, is likewise exposed by a later lookup that hits or misses wrongly. A timing fault in the two-cycle handshake shows on `done_o` and `ready_o` within two cycles of the accepting edge.

// File: rtl/lru_dir_pkg.sv
package lru_dir_pkg;

  typedef enum logic [1:0] {
    LK_IDLE = 2'd0,
    LK_CMP  = 2'd1,
    LK_RESP = 2'd2
  } lk_state_e;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/lru_set_store.sv
module lru_set_store #(
  parameter int WAYS  = 4,
  parameter int SETS  = 8,
  parameter int TAG_W = 16,
  localparam int SET_W = lru_dir_pkg::idx_width(SETS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [SET_W-1:0]            rd_set,
  output logic [WAYS-1:0][TAG_W-1:0]  rd_row,
  input  logic                        wr_en,
  input  logic [SET_W-1:0]            wr_set,
  input  logic [WAYS-1:0][TAG_W-1:0]  wr_row
);

  logic [WAYS-1:0][TAG_W-1:0] row_q [SETS];

  // Every entry starts at zero; there is no valid bit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        row_q[s] <= '0;
      end
    end else if (wr_en) begin
      row_q[wr_set] <= wr_row;
    end
  end

  assign rd_row = row_q[rd_set];

endmodule

// File: rtl/lru_way_match.sv
module lru_way_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 16,
  localparam int IDX_W = lru_dir_pkg::idx_width(WAYS)
) (
  input  logic [WAYS-1:0][TAG_W-1:0] row,
  input  logic [TAG_W-1:0]           tag,
  output logic                       hit,
  output logic [IDX_W-1:0]           hit_idx
);

  logic [WAYS-1:0] eq;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign eq[w] = (row[w] == tag);
  end

  // Lowest slot wins: zero-filled sets may hold the same tag more than once.
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (eq[w]) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(w);
      end
    end
  end

endmodule

// File: rtl/lru_reorder.sv
module lru_reorder #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 16,
  localparam int IDX_W = lru_dir_pkg::idx_width(WAYS)
) (
  input  logic [WAYS-1:0][TAG_W-1:0] row,
  input  logic [TAG_W-1:0]           tag,
  input  logic                       hit,
  input  logic [IDX_W-1:0]           hit_idx,
  output logic [WAYS-1:0][TAG_W-1:0] new_row
);

  // Slot 0 always receives the looked-up tag (unchanged on a slot-0 hit).
  assign new_row[0] = tag;

  if (WAYS > 1) begin : g_shift
    for (genvar j = 1; j < WAYS; j++) begin : g_slot
      logic take_upper;
      assign take_upper = !hit || (IDX_W'(j) <= hit_idx);
      assign new_row[j] = take_upper ? row[j-1] : row[j];
    end
  end

endmodule

// File: rtl/lru_tag_dir.sv
module lru_tag_dir #(
  parameter int WAYS  = 4,
  parameter int SETS  = 8,
  parameter int BLK_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic [BLK_W-1:0] blk_i,
  output logic             ready_o,
  output logic             done_o,
  output logic             hit_o
);
  import lru_dir_pkg::*;

  localparam int SET_W = idx_width(SETS);
  localparam int IDX_W = idx_width(WAYS);
  localparam logic [SET_W-1:0] SET_MASK = SET_W'(SETS - 1);

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  lk_state_e        state_q, state_d;
  logic [BLK_W-1:0] blk_q;
  logic             hit_q;
  logic             accept;
  logic             blk_en, hit_en;

  logic [SET_W-1:0]             set_idx;
  logic [WAYS-1:0][BLK_W-1:0]   cur_row, nxt_row;
  logic                         way_hit;
  logic [IDX_W-1:0]             way_idx;

  assign ready_o = rst_sync_q && (state_q != LK_CMP);
  assign accept  = req_i && ready_o;
  assign blk_en  = accept;
  assign hit_en  = (state_q == LK_CMP);

  always_comb begin
    state_d = state_q;
    case (state_q)
      LK_IDLE: if (accept) state_d = LK_CMP;
      LK_CMP:  state_d = LK_RESP;
      LK_RESP: state_d = accept ? LK_CMP : LK_IDLE;
      default: state_d = LK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      state_q <= LK_IDLE;
      blk_q   <= '0;
      hit_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (blk_en) blk_q <= blk_i;
      if (hit_en) hit_q <= way_hit;
    end
  end

  assign set_idx = blk_q[SET_W-1:0] & SET_MASK;

  lru_set_store #(.WAYS(WAYS), .SETS(SETS), .TAG_W(BLK_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .rd_set (set_idx),
    .rd_row (cur_row),
    .wr_en  (hit_en),
    .wr_set (set_idx),
    .wr_row (nxt_row)
  );

  lru_way_match #(.WAYS(WAYS), .TAG_W(BLK_W)) u_match (
    .row     (cur_row),
    .tag     (blk_q),
    .hit     (way_hit),
    .hit_idx (way_idx)
  );

  lru_reorder #(.WAYS(WAYS), .TAG_W(BLK_W)) u_reorder (
    .row     (cur_row),
    .tag     (blk_q),
    .hit     (way_hit),
    .hit_idx (way_idx),
    .new_row (nxt_row)
  );

  assign done_o = (state_q == LK_RESP);
  assign hit_o  = hit_q;

endmodule

// File: rtl/lru_tag_dir_chk.sv
module lru_tag_dir_chk #(
  parameter int BLK_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_i,
  input logic [BLK_W-1:0] blk_i,
  input logic             ready_o,
  input logic             done_o,
  input logic             hit_o
);

  logic             prev_vld_q, same_q;
  logic [BLK_W-1:0] prev_blk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_vld_q <= 1'b0;
      prev_blk_q <= '0;
      same_q     <= 1'b0;
    end else if (req_i && ready_o) begin
      same_q     <= prev_vld_q && (blk_i == prev_blk_q);
      prev_blk_q <= blk_i;
      prev_vld_q <= 1'b1;
    end
  end

  // R2: completion arrives exactly two cycles after acceptance
  assert_done_timing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && ready_o) |=> (!done_o ##1 done_o));

  // R2: done is a single-cycle pulse
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R3: the block is busy for the cycle after acceptance
  assert_busy_after_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && ready_o) |=> !ready_o);

  // R3: the busy phase lasts one cycle only
  assert_busy_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_o && $past(ready_o) |=> ready_o);

  // R9: the completion cycle can take a new request
  assert_ready_at_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ready_o);

  // R5: repeating the previous block finds it in slot 0
  assert_repeat_hits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && same_q) |-> hit_o);

endmodule

bind lru_tag_dir lru_tag_dir_chk #(.BLK_W(BLK_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .req_i   (req_i),
  .blk_i   (blk_i),
  .ready_o (ready_o),
  .done_o  (done_o),
  .hit_o   (hit_o)
);

// File: tb/sim_lru_tag_dir.sv
`timescale 1ns/1ps
module sim_lru_tag_dir;

  logic clk = 1'b0;
  logic rst_n;
  logic req0, req1;
  logic [15:0] blk0, blk1;
  logic rdy0, done0, hit0;
  logic rdy1, done1, hit1;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  lru_tag_dir #(.WAYS(4), .SETS(8), .BLK_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req0), .blk_i(blk0),
    .ready_o(rdy0), .done_o(done0), .hit_o(hit0));

  lru_tag_dir #(.WAYS(1), .SETS(4), .BLK_W(16)) u1 (
    .clk(clk), .rst_n(rst_n), .req_i(req1), .blk_i(blk1),
    .ready_o(rdy1), .done_o(done1), .hit_o(hit1));

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // One lookup on unit u; called and returning at a falling edge.
  task automatic lookup(input int u, input int blk, input bit exp_hit,
                        input string rq);
    logic d, h;
    while ((u == 0) ? !rdy0 : !rdy1) @(negedge clk);
    if (u == 0) begin req0 = 1'b1; blk0 = 16'(blk); end
    else        begin req1 = 1'b1; blk1 = 16'(blk); end
    @(negedge clk);
    req0 = 1'b0; req1 = 1'b0;
    d = (u == 0) ? done0 : done1;
    chk(d == 1'b0, "R2", $sformatf("done early blk %0d", blk), d, 0);
    @(negedge clk);
    d = (u == 0) ? done0 : done1;
    h = (u == 0) ? hit0 : hit1;
    chk(d == 1'b1, "R2", $sformatf("done missing blk %0d", blk), d, 1);
    chk(h == exp_hit, rq, $sformatf("hit blk %0d", blk), h, exp_hit);
  endtask

  task automatic t_reset;
    chk(rdy0 == 1'b1 && done0 == 1'b0 && hit0 == 1'b0, "R1", "u0 idle",
        {rdy0, done0, hit0}, 3'b100);
    chk(rdy1 == 1'b1 && done1 == 1'b0, "R1", "u1 idle", {rdy1, done1}, 2'b10);
  endtask

  task automatic t_zero_block;
    lookup(0, 0, 1'b1, "R8");   // zeroed entry matches block 0
    lookup(0, 8, 1'b0, "R7");   // set0 [8,0,0,0]
    lookup(0, 0, 1'b1, "R6");   // set0 [0,8,0,0]
  endtask

  task automatic t_lru_order;
    lookup(0, 1,  1'b0, "R7");
    lookup(0, 9,  1'b0, "R7");
    lookup(0, 17, 1'b0, "R7");
    lookup(0, 25, 1'b0, "R7");  // [25,17,9,1]
    lookup(0, 1,  1'b1, "R6");  // [1,25,17,9]
    lookup(0, 33, 1'b0, "R7");  // [33,1,25,17]
    lookup(0, 9,  1'b0, "R7");  // evicted: [9,33,1,25]
    lookup(0, 25, 1'b1, "R6");  // last slot: [25,9,33,1]
    lookup(0, 17, 1'b0, "R7");  // [17,25,9,33]
    lookup(0, 1,  1'b0, "R7");  // [1,17,25,9]
  endtask

  task automatic t_slot0;
    lookup(0, 1,  1'b1, "R5");  // unchanged [1,17,25,9]
    lookup(0, 17, 1'b1, "R6");  // [17,1,25,9]
  endtask

  task automatic t_sets;
    lookup(0, 2,  1'b0, "R11");
    lookup(0, 10, 1'b0, "R11");
    lookup(0, 25, 1'b1, "R11"); // set1 untouched: [25,17,1,9]
    lookup(0, 9,  1'b1, "R11"); // [9,25,17,1]
    lookup(0, 2,  1'b1, "R11");
  endtask

  task automatic t_back_to_back;
    lookup(0, 41, 1'b0, "R9");  // [41,9,25,17]
    lookup(0, 41, 1'b1, "R9");  // issued in the done cycle
    lookup(0, 1,  1'b0, "R9");  // [1,41,9,25]
    @(negedge clk);
    chk(done0 == 1'b0, "R2", "pulse width", done0, 0);
  endtask

  task automatic t_busy_ignored;
    while (!rdy0) @(negedge clk);
    req0 = 1'b1; blk0 = 16'd49;
    @(negedge clk);
    chk(rdy0 == 1'b0, "R3", "busy", rdy0, 0);
    blk0 = 16'd57;              // raised while busy
    @(negedge clk);
    req0 = 1'b0;
    chk(done0 == 1'b1 && hit0 == 1'b0, "R3", "49 miss", {done0, hit0}, 2'b10);
    @(negedge clk);
    chk(done0 == 1'b0, "R3", "no extra done", done0, 0);
    @(negedge clk);
    chk(done0 == 1'b0, "R3", "no extra done 2", done0, 0);
    lookup(0, 49, 1'b1, "R3");
    lookup(0, 57, 1'b0, "R3");  // [57,49,1,41]
  endtask

  task automatic t_full_tag;
    lookup(0, 16'h8001, 1'b0, "R4"); // [8001,57,49,1]
    lookup(0, 1,        1'b1, "R4"); // [1,8001,57,49]
    lookup(0, 16'h8001, 1'b1, "R4");
  endtask

  task automatic t_direct;
    lookup(1, 0, 1'b1, "R10");
    lookup(1, 3, 1'b0, "R10");
    lookup(1, 3, 1'b1, "R10");
    lookup(1, 7, 1'b0, "R10");
    lookup(1, 3, 1'b0, "R10");
    lookup(1, 2, 1'b0, "R10");
    lookup(1, 3, 1'b1, "R10");
  endtask

  initial begin
    rst_n = 1'b0; req0 = 1'b0; req1 = 1'b0; blk0 = '0; blk1 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_zero_block();
    t_lru_order();
    t_slot0();
    t_sets();
    t_back_to_back();
    t_busy_ignored();
    t_full_tag();
    t_direct();
    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule